// File: doc/BRIEF.md
# Next-PC Selection Unit

This block owns the program counter of a single-cycle processor core. On every clock edge it loads one of five candidate addresses: the sequential address, a conditional branch target, a region-relative jump target, an address taken from a register, or a fixed exception vector. The choice is made from the opcode and function code of the instruction currently executing, the zero indication of the main ALU, and an exception request line.

Branch targets come from an adder inside this block, so the main ALU stays free to compare the two branch operands during the same cycle. The block also provides PC+4 as an output, which the surrounding datapath uses as the link value for a jump-and-link instruction. Decoding, target arithmetic and the selection multiplexer are kept in separate submodules, and a small enumerated source code connects them.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pc` becomes 0x00000000 on that edge. Reset wins over every other input, including `exc_req`.
- R2: When no control-transfer case or exception applies, `pc` advances to `pc + 4`, wrapping modulo 2^32. Such cases include any opcode other than 000000, 000010, 000011 and 000100, and opcode 000000 with any funct other than 001000.
- R3: With opcode 000100 (branch-if-not-equal) and `alu_zero` low, the next `pc` is `pc + 4 + (offset_ext << 2)`, taken modulo 2^32.
- R4: With opcode 000100 and `alu_zero` high, the branch is not taken and the next `pc` is `pc + 4`.
- R5: With opcode 000010 (jump) or 000011 (jump-and-link), the next `pc` is `{pc[31:28], jump_field, 2'b00}`.
- R6: With opcode 000000 and funct 001000 (register jump), the next `pc` is `rs_value`, used unchanged.
- R7: When `exc_req` is high, the next `pc` is 0x80000000, whatever the other inputs are.
- R8: `pc_plus4` always equals `pc + 4` modulo 2^32.
- R9: Funct 001000 selects a register jump only when the opcode is 000000. With any other non-control opcode, that funct value has no effect and `pc` advances by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the current instruction |
| funct | input | 6 | Function field of the current instruction |
| jump_field | input | 26 | 26-bit jump index of the current instruction |
| offset_ext | input | 32 | Sign-extended 16-bit branch offset, in words |
| rs_value | input | 32 | Register value used by the register jump |
| alu_zero | input | 1 | High when the ALU result is zero (branch operands equal) |
| exc_req | input | 1 | Exception request; forces the kernel vector |
| pc | output | 32 | Current program counter |
| pc_plus4 | output | 32 | Current program counter plus 4 |

## Verification
The hardest case to reach from the ports is a region-relative jump whose upper four PC bits are non-zero. Sequential steps and short branches never leave the bottom region of the address space. To get there, the stimulus first uses a register jump to move the PC high in the address map, and then issues jumps, so that keeping `pc[31:28]` can be told apart from clearing it. In the same way, wrap-around of the sequential and branch adders only shows up when the PC sits just below 2^32, so register jumps to addresses near the top of the space, and negative branch offsets, are used on purpose. Random cycles mix every opcode class with occasional exceptions, which puts exception priority up against every other source.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int unsigned XLEN = 32;
    localparam int unsigned OPW  = 6;
    localparam int unsigned FNW  = 6;
    localparam int unsigned JFW  = 26;

    // Source code for the next program counter
    typedef enum logic [2:0] {
        SRC_SEQ    = 3'd0,
        SRC_BRANCH = 3'd1,
        SRC_JUMP   = 3'd2,
        SRC_REG    = 3'd3,
        SRC_EXC    = 3'd4
    } pc_src_e;

    localparam logic [OPW-1:0] OPC_SPECIAL = 6'b000000;
    localparam logic [OPW-1:0] OPC_BNE     = 6'b000100;
    localparam logic [OPW-1:0] OPC_JMP     = 6'b000010;
    localparam logic [OPW-1:0] OPC_JMPLNK  = 6'b000011;
    localparam logic [FNW-1:0] FN_REGJUMP  = 6'b001000;

    // All candidate addresses for one cycle
    typedef struct packed {
        logic [XLEN-1:0] seq;
        logic [XLEN-1:0] branch;
        logic [XLEN-1:0] jump;
        logic [XLEN-1:0] regtgt;
        logic [XLEN-1:0] vector;
    } tgt_set_t;

    function automatic logic is_region_jump(input logic [OPW-1:0] op);
        return (op == OPC_JMP) || (op == OPC_JMPLNK);
    endfunction

    function automatic logic is_reg_jump(input logic [OPW-1:0] op,
                                         input logic [FNW-1:0] fn);
        return (op == OPC_SPECIAL) && (fn == FN_REGJUMP);
    endfunction

endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
(
    input  logic [OPW-1:0] opcode,
    input  logic [FNW-1:0] funct,
    input  logic           alu_zero,
    input  logic           exc_req,
    output pc_src_e        src
);

    logic take_branch;

    assign take_branch = (opcode == OPC_BNE) && !alu_zero;

    // Exception first, then the instruction-driven sources
    always_comb begin
        if (exc_req) begin
            src = SRC_EXC;
        end else if (is_reg_jump(opcode, funct)) begin
            src = SRC_REG;
        end else if (is_region_jump(opcode)) begin
            src = SRC_JUMP;
        end else if (take_branch) begin
            src = SRC_BRANCH;
        end else begin
            src = SRC_SEQ;
        end
    end

endmodule

// File: rtl/npc_targets.sv
module npc_targets
    import npc_pkg::*;
#(
    parameter int unsigned     INSTR_BYTES = 4,
    parameter logic [XLEN-1:0] EXC_VEC     = 32'h8000_0000
) (
    input  logic [XLEN-1:0] pc,
    input  logic [JFW-1:0]  jump_field,
    input  logic [XLEN-1:0] offset_ext,
    input  logic [XLEN-1:0] rs_value,
    output tgt_set_t        tgt
);

    localparam int unsigned ALIGN_BITS = $clog2(INSTR_BYTES);
    localparam int unsigned KEEP_BITS  = XLEN - JFW - ALIGN_BITS;

    logic [XLEN-1:0] seq_addr;
    logic [XLEN-1:0] offset_bytes;

    assign seq_addr     = pc + XLEN'(INSTR_BYTES);
    assign offset_bytes = offset_ext << ALIGN_BITS;

    always_comb begin
        tgt.seq    = seq_addr;
        // Branch adder, separate from the main ALU
        tgt.branch = seq_addr + offset_bytes;
        tgt.jump   = {pc[XLEN-1 -: KEEP_BITS], jump_field, {ALIGN_BITS{1'b0}}};
        tgt.regtgt = rs_value;
        tgt.vector = EXC_VEC;
    end

endmodule

// File: rtl/npc_select.sv
module npc_select
    import npc_pkg::*;
(
    input  pc_src_e         src,
    input  tgt_set_t        tgt,
    output logic [XLEN-1:0] next_pc
);

    always_comb begin
        unique case (src)
            SRC_BRANCH: next_pc = tgt.branch;
            SRC_JUMP:   next_pc = tgt.jump;
            SRC_REG:    next_pc = tgt.regtgt;
            SRC_EXC:    next_pc = tgt.vector;
            default:    next_pc = tgt.seq;
        endcase
    end

endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC    = 32'h0000_0000,
    parameter logic [XLEN-1:0] EXC_VEC     = 32'h8000_0000,
    parameter int unsigned     INSTR_BYTES = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [5:0]      opcode,
    input  logic [5:0]      funct,
    input  logic [25:0]     jump_field,
    input  logic [31:0]     offset_ext,
    input  logic [31:0]     rs_value,
    input  logic            alu_zero,
    input  logic            exc_req,
    output logic [31:0]     pc,
    output logic [31:0]     pc_plus4
);

    pc_src_e         src;
    tgt_set_t        tgt;
    logic [XLEN-1:0] next_pc;
    logic [XLEN-1:0] pc_q;

    npc_decode u_decode (
        .opcode   (opcode),
        .funct    (funct),
        .alu_zero (alu_zero),
        .exc_req  (exc_req),
        .src      (src)
    );

    npc_targets #(
        .INSTR_BYTES (INSTR_BYTES),
        .EXC_VEC     (EXC_VEC)
    ) u_targets (
        .pc         (pc_q),
        .jump_field (jump_field),
        .offset_ext (offset_ext),
        .rs_value   (rs_value),
        .tgt        (tgt)
    );

    npc_select u_select (
        .src     (src),
        .tgt     (tgt),
        .next_pc (next_pc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= RESET_PC;
        end else begin
            pc_q <= next_pc;
        end
    end

    assign pc       = pc_q;
    assign pc_plus4 = tgt.seq;

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
    parameter logic [31:0] RESET_PC = 32'h0000_0000,
    parameter logic [31:0] EXC_VEC  = 32'h8000_0000
) (
    input logic        clk,
    input logic        rst,
    input logic [5:0]  opcode,
    input logic [5:0]  funct,
    input logic [25:0] jump_field,
    input logic [31:0] offset_ext,
    input logic [31:0] rs_value,
    input logic        alu_zero,
    input logic        exc_req,
    input logic [31:0] pc,
    input logic [31:0] pc_plus4
);

    logic plain_op;
    assign plain_op = (opcode != 6'b000000) && (opcode != 6'b000010) &&
                      (opcode != 6'b000011) && (opcode != 6'b000100);

    // R1
    reset_pc_chk: assert property (@(posedge clk)
        rst |=> (pc == RESET_PC));

    // R8
    seq_out_chk: assert property (@(posedge clk) disable iff (rst)
        pc_plus4 == pc + 32'd4);

    // R7
    exc_vec_chk: assert property (@(posedge clk) disable iff (rst)
        exc_req |=> (pc == EXC_VEC));

    // R3
    bne_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (opcode == 6'b000100 && !alu_zero && !exc_req)
        |=> (pc == $past(pc) + 32'd4 + ($past(offset_ext) << 2)));

    // R4
    bne_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (opcode == 6'b000100 && alu_zero && !exc_req)
        |=> (pc == $past(pc) + 32'd4));

    // R5
    region_jump_chk: assert property (@(posedge clk) disable iff (rst)
        ((opcode == 6'b000010 || opcode == 6'b000011) && !exc_req)
        |=> (pc == {$past(pc[31:28]), $past(jump_field), 2'b00}));

    // R6
    reg_jump_chk: assert property (@(posedge clk) disable iff (rst)
        (opcode == 6'b000000 && funct == 6'b001000 && !exc_req)
        |=> (pc == $past(rs_value)));

    // R2
    plain_step_chk: assert property (@(posedge clk) disable iff (rst)
        (plain_op && !exc_req) |=> (pc == $past(pc) + 32'd4));

endmodule

bind npc_unit npc_unit_chk #(
    .RESET_PC (RESET_PC),
    .EXC_VEC  (EXC_VEC)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .opcode     (opcode),
    .funct      (funct),
    .jump_field (jump_field),
    .offset_ext (offset_ext),
    .rs_value   (rs_value),
    .alu_zero   (alu_zero),
    .exc_req    (exc_req),
    .pc         (pc),
    .pc_plus4   (pc_plus4)
);

// File: tb/test_npc_unit.sv
module test_npc_unit;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 200000;

    logic        clk = 1'b0;
    logic        rst;
    logic [5:0]  opcode;
    logic [5:0]  funct;
    logic [25:0] jump_field;
    logic [31:0] offset_ext;
    logic [31:0] rs_value;
    logic        alu_zero;
    logic        exc_req;
    logic [31:0] pc;
    logic [31:0] pc_plus4;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] exp_pc;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    npc_unit i_npc_unit (
        .clk        (clk),
        .rst        (rst),
        .opcode     (opcode),
        .funct      (funct),
        .jump_field (jump_field),
        .offset_ext (offset_ext),
        .rs_value   (rs_value),
        .alu_zero   (alu_zero),
        .exc_req    (exc_req),
        .pc         (pc),
        .pc_plus4   (pc_plus4)
    );

    function automatic logic [31:0] model_next(
        input logic [31:0] cur, input logic [5:0] op, input logic [5:0] fn,
        input logic [25:0] jf, input logic [31:0] off, input logic [31:0] rv,
        input logic z, input logic e);
        if (e)                                  return 32'h8000_0000;
        if (op == 6'b000000 && fn == 6'b001000) return rv;
        if (op == 6'b000010 || op == 6'b000011) return {cur[31:28], jf, 2'b00};
        if (op == 6'b000100 && !z)              return cur + 32'd4 + {off[29:0], 2'b00};
        return cur + 32'd4;
    endfunction

    function automatic string req_of(input logic [5:0] op, input logic [5:0] fn,
                                     input logic z, input logic e);
        if (e)                                  return "R7";
        if (op == 6'b000000 && fn == 6'b001000) return "R6";
        if (op == 6'b000010 || op == 6'b000011) return "R5";
        if (op == 6'b000100)                    return z ? "R4" : "R3";
        if (fn == 6'b001000)                    return "R9";
        return "R2";
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", req, act, expv);
        end
    endtask

    // Drive at the falling edge, let one rising edge load the PC, check at the next falling edge
    task automatic step(input logic [5:0] op, input logic [5:0] fn, input logic [25:0] jf,
                        input logic [31:0] off, input logic [31:0] rv,
                        input logic z, input logic e);
        logic [31:0] nxt;
        string       req;
        opcode = op; funct = fn; jump_field = jf; offset_ext = off;
        rs_value = rv; alu_zero = z; exc_req = e;
        nxt = model_next(exp_pc, op, fn, jf, off, rv, z, e);
        req = req_of(op, fn, z, e);
        @(posedge clk);
        @(negedge clk);
        exp_pc = nxt;
        check(req, pc, exp_pc);
        check("R8", pc_plus4, exp_pc + 32'd4);
    endtask

    task automatic do_reset(input logic e);
        rst = 1'b1; exc_req = e; opcode = 6'b000010; jump_field = 26'h3FF_FFFF;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        exp_pc = 32'h0;
        // R1 reset value, also with an exception request pending
        check("R1", pc, 32'h0);
        check("R8", pc_plus4, 32'h4);
    endtask

    initial begin
        rst = 1'b1; opcode = '0; funct = '0; jump_field = '0; offset_ext = '0;
        rs_value = '0; alu_zero = 1'b0; exc_req = 1'b0; exp_pc = '0;
        @(negedge clk);
        @(negedge clk);
        do_reset(1'b0);

        // R2 sequential steps: load, store, R-type add
        step(6'b100011, 6'h00, 26'h0, 32'h0, 32'h0, 1'b0, 1'b0);
        step(6'b101011, 6'h00, 26'h0, 32'h0, 32'h0, 1'b1, 1'b0);
        step(6'b000000, 6'b100000, 26'h0, 32'h0, 32'hDEAD_BEEF, 1'b0, 1'b0);
        // R3 forward, then backward, taken branch
        step(6'b000100, 6'h00, 26'h0, 32'h0000_0010, 32'h0, 1'b0, 1'b0);
        step(6'b000100, 6'h00, 26'h0, 32'hFFFF_FFF8, 32'h0, 1'b0, 1'b0);
        // R4 not-taken branch
        step(6'b000100, 6'h00, 26'h0, 32'h0000_0100, 32'h0, 1'b1, 1'b0);
        // R6 register jump high in memory, then R5 jumps keep upper bits
        step(6'b000000, 6'b001000, 26'h0, 32'h0, 32'hF000_1234, 1'b0, 1'b0);
        step(6'b000010, 6'h00, 26'h155_5555, 32'h0, 32'h0, 1'b0, 1'b0);
        step(6'b000011, 6'h00, 26'h2AA_AAAA, 32'h0, 32'h0, 1'b0, 1'b0);
        // R9 jr funct with a non-special opcode
        step(6'b001000, 6'b001000, 26'h0, 32'h0, 32'h1234_5678, 1'b0, 1'b0);
        // R8 and R2 wrap at the top of the address space
        step(6'b000000, 6'b001000, 26'h0, 32'h0, 32'hFFFF_FFFC, 1'b0, 1'b0);
        step(6'b100011, 6'h00, 26'h0, 32'h0, 32'h0, 1'b0, 1'b0);
        // R3 branch adder wrap
        step(6'b000000, 6'b001000, 26'h0, 32'h0, 32'hFFFF_FFF0, 1'b0, 1'b0);
        step(6'b000100, 6'h00, 26'h0, 32'h0000_0008, 32'h0, 1'b0, 1'b0);
        // R7 exception over register jump, jump and taken branch
        step(6'b000000, 6'b001000, 26'h0, 32'h0, 32'h0000_4000, 1'b0, 1'b1);
        step(6'b000010, 6'h00, 26'h123_4567, 32'h0, 32'h0, 1'b0, 1'b1);
        step(6'b000100, 6'h00, 26'h0, 32'h0000_0040, 32'h0, 1'b0, 1'b1);
        // R1 reset beats an exception request
        do_reset(1'b1);

        // Random mix
        void'($urandom(32'd20240611));
        for (int i = 0; i < 3000; i++) begin
            logic [5:0] op;
            logic [5:0] fn;
            int unsigned pick;
            pick = $urandom_range(0, 9);
            case (pick)
                0, 1:    op = 6'b000000;
                2, 3:    op = 6'b000100;
                4:       op = 6'b000010;
                5:       op = 6'b000011;
                default: op = 6'($urandom);
            endcase
            fn = ($urandom_range(0, 2) == 0) ? 6'b001000 : 6'($urandom);
            step(op, fn, 26'($urandom), {{14{1'($urandom)}}, 18'($urandom)},
                 $urandom, 1'($urandom), ($urandom_range(0, 15) == 0));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule